// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the software-visible register file of a single DMA channel. A host reaches it over a simple 32-bit request/response bus that accepts 16-bit and 32-bit accesses and answers every request exactly one cycle later. The bank keeps the setup registers: descriptor pointer, start address, configuration, X/Y counts and signed X/Y modifies. It also keeps a live view of the channel: current descriptor pointer, current address, current X/Y counts and a status word.

A write to the configuration register launches or halts the channel. On launch the bank copies the setup values into the current registers, raises the run flag and pulses `ch_start` toward the transfer engine. On halt it drops the run flag and pulses `ch_stop`. While the channel runs, the setup registers, the current registers and the peripheral map are frozen against bus writes. During that time the engine keeps the current registers up to date through its own update port, and it reports completion and errors the same way. Descriptor fetch and data movement are handled elsewhere.

Register word offsets (byte address bits 5:2) are: 0 descriptor pointer, 1 start address, 2 configuration, 4 X count, 5 X modify, 6 Y count, 7 Y modify, 8 current descriptor, 9 current address, 10 status, 11 peripheral map, 12 current X count, 14 current Y count. Offsets 3, 13 and 15 are reserved.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register reads zero, except the peripheral map, which reads the parameter `PMAP_RST` (default 0x0040), and `ch_run`, `ch_start` and `ch_stop` are low.
- R2: An access whose `req_size` is neither 1 (16-bit) nor 2 (32-bit), or whose byte address bits 1:0 are not zero, returns `rsp_err`=1 with read data zero and changes no register.
- R3: A write to reserved offset 3, 13 or 15 returns `rsp_err`=1. A read of those offsets returns zero with `rsp_err`=0.
- R4: A 16-bit read returns the low 16 bits of the register zero-extended. A 16-bit write to a 32-bit register (offsets 0, 1, 8, 9) replaces only bits 15:0. The 16-bit registers take bits 15:0 of the write data for either size.
- R5: While the run flag is set, bus writes to offsets 0, 1, 4 to 9, 11, 12 and 14 are discarded without error.
- R6: The status register holds DONE at bit 0, ERR at bit 1 and RUN at bit 3. Writing a 1 to bit 0 or bit 1 clears that bit. Writes never change RUN.
- R7: A configuration write with bit 0 set raises RUN and pulses `ch_start` for one cycle in the response cycle. It also loads the current descriptor pointer from offset 0 and the current address from offset 1. It loads each current count from its count register, with a count of zero loaded as 0xFFFF.
- R8: A configuration write with bit 0 clear drops RUN and pulses `ch_stop` for one cycle in the response cycle.
- R9: Bit 6 of the peripheral map (channel type) keeps its value on every write. The other bits take the written value.
- R10: At launch, ERR is set if the start address is not a multiple of the element size selected by configuration bits 3:2 (00 byte, 01 halfword, 10 word).
- R11: While RUN is set, a cycle with `eng_upd` high loads the current address, descriptor pointer, X count and Y count from the engine port. While RUN is clear, `eng_upd` has no effect.
- R12: While RUN is set, `eng_done` clears RUN and sets DONE, and `eng_err` sets ERR.
- R13: `rsp_valid` is high exactly in the cycle after each cycle with `req_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 6 | Byte offset within the bank |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 32 | Read data |
| ch_start | output | 1 | Launch pulse to the engine |
| ch_stop | output | 1 | Halt pulse to the engine |
| ch_run | output | 1 | Run flag |
| ch_config | output | 16 | Configuration register |
| eng_upd | input | 1 | Engine current-state update |
| eng_addr | input | 32 | New current address |
| eng_desc | input | 32 | New current descriptor pointer |
| eng_xcnt | input | 16 | New current X count |
| eng_ycnt | input | 16 | New current Y count |
| eng_done | input | 1 | Engine finished the work |
| eng_err | input | 1 | Engine saw an error |

## Verification
The bank is driven with full-word and half-word writes and reads across every offset. This separates the two merge paths and shows that reserved reads differ from reserved writes. The same registers are then written with the channel idle and with it running, so that the freeze set and the always-writable configuration and status registers are told apart. Launches are issued with zero and non-zero counts and with aligned and misaligned start addresses, which exercises the 0xFFFF substitution and the ERR check. Engine updates are sent both while running and while idle, to separate accepted from ignored state.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter logic [15:0] PMAP_RST = 16'h0040
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [5:0]  req_addr,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic [31:0] rsp_rdata,
  output logic        ch_start,
  output logic        ch_stop,
  output logic        ch_run,
  output logic [15:0] ch_config,
  input  logic        eng_upd,
  input  logic [31:0] eng_addr,
  input  logic [31:0] eng_desc,
  input  logic [15:0] eng_xcnt,
  input  logic [15:0] eng_ycnt,
  input  logic        eng_done,
  input  logic        eng_err
);
  localparam logic [3:0] I_NDP = 4'd0, I_SA = 4'd1, I_CFG = 4'd2, I_XC = 4'd4,
                         I_XM = 4'd5, I_YC = 4'd6, I_YM = 4'd7, I_CDP = 4'd8,
                         I_CA = 4'd9, I_STAT = 4'd10, I_PMAP = 4'd11,
                         I_CXC = 4'd12, I_CYC = 4'd14;

  logic [31:0] ndp_q, sa_q, cdp_q, ca_q;
  logic [15:0] cfg_q, xc_q, xm_q, yc_q, ym_q, pmap_q, cxc_q, cyc_q;
  logic        run_q, done_q, err_q;
  logic [31:0] rd;

  wire [3:0] idx     = req_addr[5:2];
  wire       wide    = req_size == 2'd2;
  wire       size_ok = (req_size == 2'd1) || wide;
  wire       rsv     = (idx == 4'd3) || (idx == 4'd13) || (idx == 4'd15);
  wire       bad     = !size_ok || (req_addr[1:0] != 2'b00) || (req_write && rsv);
  wire       wr      = req_valid && req_write && !bad;
  wire       open_wr = wr && !run_q;
  wire       cfg_on  = wr && (idx == I_CFG) && req_wdata[0];
  wire       cfg_off = wr && (idx == I_CFG) && !req_wdata[0];
  wire       stat_wr = wr && (idx == I_STAT);
  wire       eng_ok  = eng_upd && run_q;
  wire       mis     = ((req_wdata[3:2] == 2'b01) && sa_q[0]) ||
                       ((req_wdata[3:2] == 2'b10) && (sa_q[1:0] != 2'b00));

  function automatic logic [31:0] merge(input logic [31:0] old, input logic full,
                                        input logic [31:0] d);
    return full ? d : {old[31:16], d[15:0]};
  endfunction

  always_comb begin
    case (idx)
      I_NDP:   rd = ndp_q;
      I_SA:    rd = sa_q;
      I_CFG:   rd = {16'h0, cfg_q};
      I_XC:    rd = {16'h0, xc_q};
      I_XM:    rd = {16'h0, xm_q};
      I_YC:    rd = {16'h0, yc_q};
      I_YM:    rd = {16'h0, ym_q};
      I_CDP:   rd = cdp_q;
      I_CA:    rd = ca_q;
      I_STAT:  rd = {28'h0, run_q, 1'b0, err_q, done_q};
      I_PMAP:  rd = {16'h0, pmap_q};
      I_CXC:   rd = {16'h0, cxc_q};
      I_CYC:   rd = {16'h0, cyc_q};
      default: rd = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ndp_q <= '0; sa_q <= '0; cdp_q <= '0; ca_q <= '0;
      cfg_q <= '0; xc_q <= '0; xm_q <= '0; yc_q <= '0; ym_q <= '0;
      cxc_q <= '0; cyc_q <= '0; pmap_q <= PMAP_RST;
      run_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_rdata <= '0;
      ch_start <= 1'b0; ch_stop <= 1'b0;
    end else begin
      if (open_wr && idx == I_NDP) ndp_q <= merge(ndp_q, wide, req_wdata);
      if (open_wr && idx == I_SA)  sa_q  <= merge(sa_q, wide, req_wdata);
      if (open_wr && idx == I_XC)  xc_q  <= req_wdata[15:0];
      if (open_wr && idx == I_XM)  xm_q  <= req_wdata[15:0];
      if (open_wr && idx == I_YC)  yc_q  <= req_wdata[15:0];
      if (open_wr && idx == I_YM)  ym_q  <= req_wdata[15:0];
      if (open_wr && idx == I_PMAP) pmap_q <= {req_wdata[15:7], pmap_q[6], req_wdata[5:0]};
      if (wr && idx == I_CFG) cfg_q <= req_wdata[15:0];

      if (cfg_on) begin
        cdp_q <= ndp_q;
        ca_q  <= sa_q;
        cxc_q <= (xc_q == 16'h0) ? 16'hFFFF : xc_q;
        cyc_q <= (yc_q == 16'h0) ? 16'hFFFF : yc_q;
      end else if (eng_ok) begin
        cdp_q <= eng_desc;
        ca_q  <= eng_addr;
        cxc_q <= eng_xcnt;
        cyc_q <= eng_ycnt;
      end else begin
        if (open_wr && idx == I_CDP) cdp_q <= merge(cdp_q, wide, req_wdata);
        if (open_wr && idx == I_CA)  ca_q  <= merge(ca_q, wide, req_wdata);
        if (open_wr && idx == I_CXC) cxc_q <= req_wdata[15:0];
        if (open_wr && idx == I_CYC) cyc_q <= req_wdata[15:0];
      end

      if (cfg_on)                 run_q <= 1'b1;
      else if (cfg_off)           run_q <= 1'b0;
      else if (run_q && eng_done) run_q <= 1'b0;

      done_q <= (done_q && !(stat_wr && req_wdata[0])) || (run_q && eng_done);
      err_q  <= (err_q && !(stat_wr && req_wdata[1])) || (run_q && eng_err) || (cfg_on && mis);

      rsp_valid <= req_valid;
      rsp_err   <= req_valid && bad;
      rsp_rdata <= (req_valid && !req_write && !bad) ? (wide ? rd : {16'h0, rd[15:0]}) : 32'h0;
      ch_start  <= cfg_on;
      ch_stop   <= cfg_off;
    end
  end

  assign ch_run    = run_q;
  assign ch_config = cfg_q;
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [5:0]  req_addr,
  input logic [1:0]  req_size,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic        ch_start,
  input logic        ch_stop,
  input logic        ch_run,
  input logic        eng_done,
  input logic [31:0] ndp
);
  // R13
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R13
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R2
  bad_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 2'd1 && req_size != 2'd2) |=> rsp_err);
  // R7
  start_sets_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_start |-> ch_run);
  // R8
  stop_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_stop |-> !ch_run);
  // R7
  pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ch_start, ch_stop}));
  // R5
  frozen_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_run && req_valid && req_write && req_addr == 6'h00) |=> $stable(ndp));
  // R6
  status_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_run && !eng_done && req_valid && req_write && req_addr == 6'h28) |=> ch_run);
endmodule

bind dma_chan_regs dma_chan_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .ch_start(ch_start), .ch_stop(ch_stop), .ch_run(ch_run),
  .eng_done(eng_done), .ndp(ndp_q)
);

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err, ch_start, ch_stop, ch_run;
  logic [31:0] rsp_rdata;
  logic [15:0] ch_config;
  logic        eng_upd = 1'b0, eng_done = 1'b0, eng_err = 1'b0;
  logic [31:0] eng_addr = '0, eng_desc = '0;
  logic [15:0] eng_xcnt = '0, eng_ycnt = '0;

  always #2 clk = ~clk;

  dma_chan_regs u_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .ch_start(ch_start), .ch_stop(ch_stop), .ch_run(ch_run), .ch_config(ch_config),
    .eng_upd(eng_upd), .eng_addr(eng_addr), .eng_desc(eng_desc),
    .eng_xcnt(eng_xcnt), .eng_ycnt(eng_ycnt), .eng_done(eng_done), .eng_err(eng_err)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_reg [16];
  bit m_start, m_stop, m_rspv, m_rspe;
  logic [31:0] m_rd;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    @(negedge clk);
    chk(tag, "ch_run", 32'(ch_run), 32'(m_reg[10][3]));
    chk(tag, "ch_start", 32'(ch_start), 32'(m_start));
    chk(tag, "ch_stop", 32'(ch_stop), 32'(m_stop));
    chk(tag, "ch_config", 32'(ch_config), m_reg[2] & 32'hFFFF);
    chk(tag, "rsp_valid", 32'(rsp_valid), 32'(m_rspv));
    if (m_rspv) begin
      chk(tag, "rsp_err", 32'(rsp_err), 32'(m_rspe));
      chk(tag, "rsp_rdata", rsp_rdata, m_rd);
    end
    m_start = 0; m_stop = 0; m_rspv = 0;
  endtask

  task automatic bus(input bit wr, input logic [5:0] a, input logic [1:0] sz,
                     input logic [31:0] d, input string tag);
    int i = int'(a[5:2]);
    bit ok = (sz == 2'd1 || sz == 2'd2) && a[1:0] == 2'b00;
    bit rsv = (i == 3 || i == 13 || i == 15);
    bit run = m_reg[10][3];
    m_rspe = !ok || (wr && rsv);
    m_rd = 32'h0;
    if (!wr && ok && !rsv) m_rd = (sz == 2'd1) ? (m_reg[i] & 32'hFFFF) : m_reg[i];
    if (wr && !m_rspe) begin
      case (i)
        2: begin
          m_reg[2] = d & 32'hFFFF;
          if (d[0]) begin
            m_reg[10][3] = 1; m_start = 1;
            m_reg[8] = m_reg[0]; m_reg[9] = m_reg[1];
            m_reg[12] = (m_reg[4] == 0) ? 32'hFFFF : m_reg[4];
            m_reg[14] = (m_reg[6] == 0) ? 32'hFFFF : m_reg[6];
            if ((d[3:2] == 2'b01 && m_reg[1][0]) || (d[3:2] == 2'b10 && m_reg[1][1:0] != 0))
              m_reg[10][1] = 1;
          end else begin
            m_reg[10][3] = 0; m_stop = 1;
          end
        end
        10: m_reg[10] = m_reg[10] & ~(d & 32'h3);
        11: if (!run) m_reg[11] = (m_reg[11] & 32'h40) | (d & 32'hFFBF);
        default: if (!run) begin
          if (i == 0 || i == 1 || i == 8 || i == 9)
            m_reg[i] = (sz == 2'd2) ? d : {m_reg[i][31:16], d[15:0]};
          else
            m_reg[i] = d & 32'hFFFF;
        end
      endcase
    end
    m_rspv = 1;
    req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    cyc(tag);
    req_valid = 0; req_write = 0;
  endtask

  task automatic eng(input logic [31:0] a, input logic [31:0] dsc, input logic [15:0] x,
                     input logic [15:0] y, input bit upd, input bit dn, input bit er,
                     input string tag);
    if (m_reg[10][3]) begin
      if (upd) begin m_reg[9] = a; m_reg[8] = dsc; m_reg[12] = {16'h0, x}; m_reg[14] = {16'h0, y}; end
      if (dn) begin m_reg[10][3] = 0; m_reg[10][0] = 1; end
      if (er) m_reg[10][1] = 1;
    end
    eng_upd = upd; eng_done = dn; eng_err = er;
    eng_addr = a; eng_desc = dsc; eng_xcnt = x; eng_ycnt = y;
    cyc(tag);
    eng_upd = 0; eng_done = 0; eng_err = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) m_reg[k] = 32'h0;
    m_reg[11] = 32'h40;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    cyc("R1");
    for (int k = 0; k < 16; k++) bus(0, 6'(k * 4), 2'd2, 32'h0, "R1");

    bus(1, 6'h00, 2'd2, 32'h1234_5678, "R4");
    bus(1, 6'h00, 2'd1, 32'hAAAA_BBBB, "R4");
    bus(0, 6'h00, 2'd2, 32'h0, "R4");
    bus(0, 6'h00, 2'd1, 32'h0, "R4");
    bus(1, 6'h14, 2'd2, 32'hDEAD_FFFE, "R4");
    bus(0, 6'h14, 2'd2, 32'h0, "R4");

    bus(1, 6'h00, 2'd0, 32'h0000_0011, "R2");
    bus(1, 6'h00, 2'd3, 32'h0000_0022, "R2");
    bus(0, 6'h00, 2'd3, 32'h0, "R2");
    bus(1, 6'h0C, 2'd0, 32'h5, "R2");
    bus(1, 6'h02, 2'd1, 32'h7777, "R2");
    bus(0, 6'h00, 2'd2, 32'h0, "R2");

    bus(1, 6'h0C, 2'd2, 32'h1, "R3");
    bus(1, 6'h34, 2'd1, 32'h1, "R3");
    bus(1, 6'h3C, 2'd2, 32'h1, "R3");
    bus(0, 6'h3C, 2'd2, 32'h0, "R3");
    bus(0, 6'h34, 2'd1, 32'h0, "R3");

    bus(1, 6'h2C, 2'd2, 32'h0000_0000, "R9");
    bus(0, 6'h2C, 2'd2, 32'h0, "R9");
    bus(1, 6'h2C, 2'd1, 32'h0000_FFBF, "R9");
    bus(0, 6'h2C, 2'd2, 32'h0, "R9");

    bus(1, 6'h04, 2'd2, 32'h0000_1000, "R7");
    bus(1, 6'h10, 2'd2, 32'h0, "R7");
    bus(1, 6'h18, 2'd2, 32'h5, "R7");
    bus(1, 6'h08, 2'd2, 32'h0000_0089, "R7");
    bus(0, 6'h20, 2'd2, 32'h0, "R7");
    bus(0, 6'h24, 2'd2, 32'h0, "R7");
    bus(0, 6'h30, 2'd2, 32'h0, "R7");
    bus(0, 6'h38, 2'd2, 32'h0, "R7");
    bus(0, 6'h28, 2'd2, 32'h0, "R10");

    bus(1, 6'h00, 2'd2, 32'hCAFE_0000, "R5");
    bus(1, 6'h10, 2'd2, 32'h9, "R5");
    bus(1, 6'h2C, 2'd2, 32'h1111, "R5");
    bus(1, 6'h30, 2'd2, 32'h3, "R5");
    bus(1, 6'h24, 2'd1, 32'h3, "R5");
    for (int k = 0; k < 16; k++) bus(0, 6'(k * 4), 2'd2, 32'h0, "R5");
    bus(1, 6'h28, 2'd2, 32'hFFFF_FFFF, "R6");
    bus(0, 6'h28, 2'd2, 32'h0, "R6");

    eng(32'h0000_2000, 32'h0000_3000, 16'h0040, 16'h0003, 1, 0, 0, "R11");
    bus(0, 6'h24, 2'd2, 32'h0, "R11");
    bus(0, 6'h20, 2'd2, 32'h0, "R11");
    bus(0, 6'h30, 2'd2, 32'h0, "R11");
    bus(0, 6'h38, 2'd2, 32'h0, "R11");
    eng(32'h0, 32'h0, 16'h0, 16'h0, 0, 0, 1, "R12");
    bus(0, 6'h28, 2'd2, 32'h0, "R12");
    eng(32'h0, 32'h0, 16'h0, 16'h0, 0, 1, 0, "R12");
    bus(0, 6'h28, 2'd2, 32'h0, "R12");

    bus(1, 6'h28, 2'd1, 32'h1, "R6");
    bus(0, 6'h28, 2'd2, 32'h0, "R6");
    bus(1, 6'h28, 2'd2, 32'h2, "R6");
    bus(0, 6'h28, 2'd2, 32'h0, "R6");

    eng(32'h5555_5555, 32'h6666_6666, 16'h7777, 16'h8888, 1, 1, 1, "R11");
    bus(0, 6'h24, 2'd2, 32'h0, "R11");
    bus(0, 6'h28, 2'd2, 32'h0, "R11");

    bus(1, 6'h04, 2'd2, 32'h0000_1001, "R10");
    bus(1, 6'h08, 2'd2, 32'h0000_0005, "R10");
    bus(0, 6'h28, 2'd2, 32'h0, "R10");
    bus(1, 6'h08, 2'd2, 32'h0000_0004, "R8");
    bus(0, 6'h28, 2'd2, 32'h0, "R8");
    bus(1, 6'h28, 2'd2, 32'h3, "R6");
    bus(1, 6'h08, 2'd2, 32'h0000_0001, "R10");
    bus(0, 6'h28, 2'd2, 32'h0, "R10");
    bus(1, 6'h08, 2'd1, 32'h0000_0000, "R8");
    cyc("R13");
    bus(0, 6'h28, 2'd2, 32'h0, "R13");
    cyc("R13");

    summary();
    $finish;
  end
endmodule